// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a byte-wide 128K x 8 parallel NOR-style flash device. It watches the write bus: an address, a data byte and an active-low write strobe. It then decides which operation the host has asked for. Commands begin with a two-write unlock prefix, where the address is compared on its low 15 bits. Byte program takes four writes. Chip erase and sector erase each take six writes. A single reset write, or the unlocked three-write reset, returns the device to array reads.

The block drives three things. The first is a read-source select, which tells the data-out mux whether to show the array, the identifier/protection query byte, or the status path. The second is a one-cycle program request, with the address captured on the strobe's falling edge and the data captured on its rising edge. The third is a one-cycle erase request with a whole-chip flag and a sector index. The embedded operation is outside this block and reports back through a `busy` input. An error flag raised by the embedded operation puts the block in a fault mode, and only a reset command clears it.

Top module: `flash_cmd_decoder`

States of the sequence machine and their transitions:

| State | Meaning | Next state on a write |
|---|---|---|
| S_IDLE | no sequence open | 5555h/AAh goes to S_UNLK1 |
| S_UNLK1 | first unlock byte seen | 2AAAh/55h goes to S_UNLK2 |
| S_UNLK2 | unlock complete | 90h sets identifier mode; A0h goes to S_PROG; 80h goes to S_ER1; F0h resets |
| S_PROG | program set up | any write fires a program request |
| S_ER1 | erase set up | 5555h/AAh goes to S_ER2 |
| S_ER2 | second unlock, first byte seen | 2AAAh/55h goes to S_ER3 |
| S_ER3 | erase armed | 5555h/10h starts a chip erase; 30h at any address starts a sector erase |

Any other write returns the machine to S_IDLE.

The modes are M_READ, M_IDENT and M_FAULT. A completed command moves the block between them, and a rising error flag moves it to M_FAULT.

## Requirements
- R1: After reset the block is in read mode: `rd_src` is 0 (array), and no program or erase request is asserted.
- R2: A write of F0h at any address, in any sequence state except S_PROG, returns the block to read mode (`rd_src` = 0).
- R3: The sequence 5555h/AAh, 2AAAh/55h, 5555h/F0h returns the block from identifier mode to read mode.
- R4: Unlock followed by 5555h/90h sets `rd_src` = 1 (query). In this mode `query_data` is 01h when `rd_addr[1:0]` = 00 and 20h when it is 01, whatever the upper address bits are.
- R5: In identifier mode, with `rd_addr[1:0]` = 10, `query_data` is 0000000b followed by `sect_prot[rd_addr[16:14]]`, so bit 0 = 1 means the sector is protected.
- R6: Identifier mode survives reads and broken sequences. It ends only when a command completes.
- R7: Unlock, then 5555h/A0h, then a fourth write, pulses `prog_req` for one cycle. `prog_addr` is the address present at that write's strobe fall, and `prog_data` is the data present at its strobe rise, including F0h. The pulse appears in the cycle after the clock edge that first samples the strobe high.
- R8: Unlock, 5555h/80h, unlock, 5555h/10h pulses `erase_req` with `erase_chip` = 1 and `erase_sector` = 0.
- R9: The same five-write prefix followed by 30h at any address pulses `erase_req` with `erase_chip` = 0 and `erase_sector` = that address's bits 16:14.
- R10: While `busy` is 1, writes have no effect: no request is issued and an open sequence keeps its place. `rd_src` is 2 (status) while `busy` is 1.
- R11: A rising `err_flag` forces fault mode (`rd_src` = 2). Only a reset command leaves fault mode. Program and erase sequences are refused while in fault mode.
- R12: A write that does not match its slot aborts the open sequence. Unlock addresses are compared on bits 14:0 only, so 1D555h counts as 5555h.
- R13: `prog_req` and `erase_req` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| we_n | input | 1 | write strobe, active low |
| bus_addr | input | 17 | write address |
| bus_wdata | input | 8 | write data |
| busy | input | 1 | embedded operation in progress |
| err_flag | input | 1 | embedded operation error |
| rd_addr | input | 17 | read address |
| sect_prot | input | 8 | per-sector protection bits |
| rd_src | output | 2 | 0 array, 1 query, 2 status |
| query_data | output | 8 | identifier / protection byte |
| prog_req | output | 1 | program request pulse |
| prog_addr | output | 17 | program address |
| prog_data | output | 8 | program data |
| erase_req | output | 1 | erase request pulse |
| erase_chip | output | 1 | 1 = whole chip |
| erase_sector | output | 3 | sector index |

## Verification
The hardest situation to reach from the ports is `busy` rising in the middle of an open unlock sequence. The bench must show that a write made during `busy` neither advances nor aborts that sequence. To do this, the stimulus first sends both unlock writes and then raises `busy`. During `busy` it writes the identifier command. After `busy` drops, it finishes with a program command. The resulting program request, together with `rd_src` still reading 0, proves that the ignored write left the sequence in its place. Fault mode is reached by pulsing `err_flag` between writes, and the bench then checks that a full program sequence produces no request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_UNLK1, S_UNLK2, S_PROG, S_ER1, S_ER2, S_ER3
    } seq_e;

    typedef enum logic [1:0] {
        M_READ, M_IDENT, M_FAULT
    } mode_e;

    localparam logic [1:0] SRC_ARRAY  = 2'd0;
    localparam logic [1:0] SRC_QUERY  = 2'd1;
    localparam logic [1:0] SRC_STATUS = 2'd2;

    localparam logic [7:0] CMD_KEY1  = 8'hAA;
    localparam logic [7:0] CMD_KEY2  = 8'h55;
    localparam logic [7:0] CMD_RESET = 8'hF0;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_SECT  = 8'h30;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] lat_addr
);
    logic we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            lat_addr <= '0;
        end else begin
            we_q <= we_n;
            if (we_q && !we_n)
                lat_addr <= bus_addr;
        end
    end

    // strobe rise: data is taken at this edge by the sequencer
    assign wr_evt = !we_q && we_n;
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W      = 17,
    parameter int                DATA_W      = 8,
    parameter int                SECT_W      = 3,
    parameter int                CMP_W       = 15,
    parameter logic [CMP_W-1:0]  UNLK_ADDR_A = 15'h5555,
    parameter logic [CMP_W-1:0]  UNLK_ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              err_flag,
    output mode_e             mode,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [SECT_W-1:0] erase_sector
);
    seq_e  seq, nxt_seq;
    mode_e nxt_mode;
    logic  err_q;
    logic  fire_prog, fire_erase, fire_chip;
    logic  hit_a, hit_b, err_rise, take;

    assign hit_a    = wr_addr[CMP_W-1:0] == UNLK_ADDR_A;
    assign hit_b    = wr_addr[CMP_W-1:0] == UNLK_ADDR_B;
    assign err_rise = err_flag && !err_q;
    assign take     = wr_evt && !busy;

    always_comb begin
        nxt_seq    = seq;
        nxt_mode   = mode;
        fire_prog  = 1'b0;
        fire_erase = 1'b0;
        fire_chip  = 1'b0;
        if (err_rise) begin
            nxt_mode = M_FAULT;
            nxt_seq  = S_IDLE;
        end else if (take) begin
            if (seq == S_PROG) begin
                fire_prog = 1'b1;
                nxt_mode  = M_READ;
                nxt_seq   = S_IDLE;
            end else if (wr_data == CMD_RESET) begin
                nxt_mode = M_READ;
                nxt_seq  = S_IDLE;
            end else begin
                unique case (seq)
                    S_IDLE:  nxt_seq = (hit_a && wr_data == CMD_KEY1) ? S_UNLK1 : S_IDLE;
                    S_UNLK1: nxt_seq = (hit_b && wr_data == CMD_KEY2) ? S_UNLK2 : S_IDLE;
                    S_UNLK2: begin
                        nxt_seq = S_IDLE;
                        if (hit_a && mode != M_FAULT) begin
                            if (wr_data == CMD_IDENT)      nxt_mode = M_IDENT;
                            else if (wr_data == CMD_PROG)  nxt_seq  = S_PROG;
                            else if (wr_data == CMD_ERASE) nxt_seq  = S_ER1;
                        end
                    end
                    S_ER1:   nxt_seq = (hit_a && wr_data == CMD_KEY1) ? S_ER2 : S_IDLE;
                    S_ER2:   nxt_seq = (hit_b && wr_data == CMD_KEY2) ? S_ER3 : S_IDLE;
                    S_ER3: begin
                        nxt_seq = S_IDLE;
                        if (hit_a && wr_data == CMD_CHIP) begin
                            fire_erase = 1'b1;
                            fire_chip  = 1'b1;
                            nxt_mode   = M_READ;
                        end else if (wr_data == CMD_SECT) begin
                            fire_erase = 1'b1;
                            nxt_mode   = M_READ;
                        end
                    end
                    S_PROG:  nxt_seq = S_IDLE;
                    default: nxt_seq = S_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq   <= S_IDLE;
            mode  <= M_READ;
            err_q <= 1'b0;
        end else begin
            seq   <= nxt_seq;
            mode  <= nxt_mode;
            err_q <= err_flag;
        end
    end

    // request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req     <= 1'b0;
            prog_addr    <= '0;
            prog_data    <= '0;
            erase_req    <= 1'b0;
            erase_chip   <= 1'b0;
            erase_sector <= '0;
        end else begin
            prog_req  <= fire_prog;
            erase_req <= fire_erase;
            if (fire_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (fire_erase) begin
                erase_chip   <= fire_chip;
                erase_sector <= fire_chip ? '0 : wr_addr[ADDR_W-1 -: SECT_W];
            end
        end
    end
endmodule

// File: rtl/flash_query_mux.sv
module flash_query_mux
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W  = 17,
    parameter int          SECT_W  = 3,
    parameter logic [7:0]  ID_MFR  = 8'h01,
    parameter logic [7:0]  ID_DEV  = 8'h20,
    localparam int         SECT_N  = 1 << SECT_W
) (
    input  mode_e             mode,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SECT_N-1:0] sect_prot,
    output logic [1:0]        rd_src,
    output logic [7:0]        query_data
);
    logic [SECT_W-1:0] sect_sel;
    logic              unused_mid;

    assign sect_sel   = rd_addr[ADDR_W-1 -: SECT_W];
    assign unused_mid = &{1'b0, rd_addr[ADDR_W-SECT_W-1:2]};

    always_comb begin
        if (busy || mode == M_FAULT) rd_src = SRC_STATUS;
        else if (mode == M_IDENT)    rd_src = SRC_QUERY;
        else                         rd_src = SRC_ARRAY;
    end

    always_comb begin
        unique case (rd_addr[1:0])
            2'b00:   query_data = ID_MFR;
            2'b01:   query_data = ID_DEV;
            2'b10:   query_data = {7'd0, sect_prot[sect_sel]};
            default: query_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3,
    localparam int SECT_N = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              err_flag,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SECT_N-1:0] sect_prot,
    output logic [1:0]        rd_src,
    output logic [7:0]        query_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              erase_chip,
    output logic [SECT_W-1:0] erase_sector
);
    logic              wr_evt;
    logic [ADDR_W-1:0] lat_addr;
    mode_e             mode;

    flash_bus_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr),
        .wr_evt(wr_evt), .lat_addr(lat_addr)
    );

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(lat_addr),
        .wr_data(bus_wdata), .busy(busy), .err_flag(err_flag), .mode(mode),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_req(erase_req), .erase_chip(erase_chip), .erase_sector(erase_sector)
    );

    flash_query_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_qry (
        .mode(mode), .busy(busy), .rd_addr(rd_addr), .sect_prot(sect_prot),
        .rd_src(rd_src), .query_data(query_data)
    );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int SECT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              err_flag,
    input logic [1:0]        rd_addr_lo,
    input logic [1:0]        rd_src,
    input logic [7:0]        query_data,
    input logic              prog_req,
    input logic              erase_req,
    input logic              erase_chip,
    input logic [SECT_W-1:0] erase_sector
);
    assert_req_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && erase_req));

    assert_prog_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    assert_erase_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    assert_busy_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(prog_req || erase_req));

    assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_src == 2'd2);

    assert_fault_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |=> rd_src == 2'd2);

    assert_ident_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src == 2'd1 && rd_addr_lo == 2'b00) |-> query_data == 8'h01);

    assert_chip_sector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_chip) |-> erase_sector == '0);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err_flag(err_flag),
    .rd_addr_lo(rd_addr[1:0]), .rd_src(rd_src), .query_data(query_data),
    .prog_req(prog_req), .erase_req(erase_req), .erase_chip(erase_chip),
    .erase_sector(erase_sector)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        busy = 1'b0;
    logic        err_flag = 1'b0;
    logic [16:0] rd_addr = '0;
    logic [7:0]  sect_prot = 8'b0100_0100;
    logic [1:0]  rd_src;
    logic [7:0]  query_data;
    logic        prog_req, erase_req, erase_chip;
    logic [16:0] prog_addr;
    logic [7:0]  prog_data;
    logic [2:0]  erase_sector;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [30:0] expq[$];

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .err_flag(err_flag),
        .rd_addr(rd_addr), .sect_prot(sect_prot), .rd_src(rd_src),
        .query_data(query_data), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_req(erase_req), .erase_chip(erase_chip),
        .erase_sector(erase_sector)
    );

    function automatic logic [30:0] item(input logic [1:0] k, input logic [16:0] a,
                                         input logic [7:0] d, input logic c,
                                         input logic [2:0] s);
        return {k, a, d, c, s};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic do_prog(input logic [16:0] a, input logic [7:0] d);
        unlock();
        wr(17'h05555, 8'hA0);
        expq.push_back(item(2'd1, a, d, 1'b0, 3'd0));
        wr(a, d);
    endtask

    task automatic do_erase(input bit chip, input logic [16:0] a);
        unlock();
        wr(17'h05555, 8'h80);
        unlock();
        expq.push_back(item(chip ? 2'd2 : 2'd3, 17'd0, 8'd0, chip, chip ? 3'd0 : a[16:14]));
        wr(a, chip ? 8'h10 : 8'h30);
    endtask

    task automatic peek(input logic [16:0] a);
        rd_addr = a;
        #1;
    endtask

    // monitor: pops expected requests (R7, R8, R9, R13)
    always @(negedge clk) begin
        if (rst_n && (prog_req || erase_req)) begin
            logic [30:0] obs;
            logic [30:0] exp;
            if (prog_req && erase_req) begin
                tests++; fails++;
                $display("FAIL R13 actual=both expected=one");
            end
            obs = prog_req ? item(2'd1, prog_addr, prog_data, 1'b0, 3'd0)
                           : item(erase_chip ? 2'd2 : 2'd3, 17'd0, 8'd0, erase_chip, erase_sector);
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R7/R8/R9/R10/R11/R12 unexpected request actual=%0h expected=none", obs);
            end else begin
                exp = expq.pop_front();
                if (obs !== exp) begin
                    fails++;
                    $display("FAIL %s actual=%0h expected=%0h",
                             exp[30:29] == 2'd1 ? "R7" : (exp[30:29] == 2'd2 ? "R8" : "R9"), obs, exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_src", rd_src, 2'd0);
        check("R1 prog_req", prog_req, 1'b0);
        check("R1 erase_req", erase_req, 1'b0);

        // R4 identifier mode
        unlock(); wr(17'h05555, 8'h90);
        check("R4 rd_src", rd_src, 2'd1);
        peek(17'h00000); check("R4 mfr", query_data, 8'h01);
        peek(17'h1A301); check("R4 dev", query_data, 8'h20);
        // R5 protection readback
        peek({3'd2, 12'd0, 2'b10}); check("R5 sector2", query_data, 8'h01);
        peek({3'd3, 12'd0, 2'b10}); check("R5 sector3", query_data, 8'h00);
        peek({3'd6, 12'h5A5, 2'b10}); check("R5 sector6", query_data, 8'h01);
        // R6 broken sequence keeps identifier mode
        wr(17'h05555, 8'hAA); wr(17'h01234, 8'h00);
        check("R6 rd_src", rd_src, 2'd1);
        // R2 single reset write
        wr(17'h00ABC, 8'hF0);
        check("R2 rd_src", rd_src, 2'd0);
        // R3 three-write reset
        unlock(); wr(17'h05555, 8'h90);
        check("R3 entered", rd_src, 2'd1);
        unlock(); wr(17'h05555, 8'hF0);
        check("R3 rd_src", rd_src, 2'd0);

        // R7 program, including F0h as data
        do_prog(17'h1F00F, 8'h5A);
        do_prog(17'h10ABC, 8'hF0);
        check("R7 mode after F0 program", rd_src, 2'd0);
        // R8, R9 erase
        do_erase(1'b1, 17'h05555);
        do_erase(1'b0, 17'h0C000);
        do_erase(1'b0, 17'h1C123);

        // R12 aliased unlock addresses
        wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h15555, 8'hA0);
        expq.push_back(item(2'd1, 17'h00042, 8'h33, 1'b0, 3'd0));
        wr(17'h00042, 8'h33);
        // R12 mismatch aborts: no request expected
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h54); wr(17'h05555, 8'hA0); wr(17'h00077, 8'h11);
        check("R12 after abort", rd_src, 2'd0);

        // R10 busy mid-sequence
        unlock();
        @(negedge clk); busy = 1'b1; #1;
        check("R10 status while busy", rd_src, 2'd2);
        wr(17'h05555, 8'h90);
        @(negedge clk); busy = 1'b0; #1;
        check("R10 ignored ident", rd_src, 2'd0);
        wr(17'h05555, 8'hA0);
        expq.push_back(item(2'd1, 17'h12345, 8'hC3, 1'b0, 3'd0));
        wr(17'h12345, 8'hC3);

        // R11 fault mode
        @(negedge clk); err_flag = 1'b1;
        @(negedge clk); err_flag = 1'b0; #1;
        check("R11 fault status", rd_src, 2'd2);
        unlock(); wr(17'h05555, 8'hA0); wr(17'h00099, 8'h66);
        check("R11 still fault", rd_src, 2'd2);
        wr(17'h00000, 8'hF0);
        check("R11 cleared by reset", rd_src, 2'd0);

        repeat (4) @(negedge clk);
        check("R7/R8/R9 pending requests", expq.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule